// File: doc/BRIEF.md
# Clock Generator Control Unit

This block holds the 24-bit control word of an on-chip clock generator and turns it into the digital controls around that generator. A 12-bit ratio field sets the multiply ratio the synthesiser is asked to reach. A 4-bit exponent field selects a power-of-two slow-down divider. One bit forces the crystal drive pin high so the crystal oscillator is off. Another bit decides whether the clock source keeps running while the chip is in its stop state. The analog loop is not modelled. A reference tick input stands in for the oscillator output. The block counts those ticks to model the settling time of the loop, and it produces the divided clock enable from them.

Software writes the whole word through a single write strobe and can always read it back. Reserved bits read back as zero. A write that changes the ratio field drops the lock flag, and lock returns only after a fixed number of reference ticks. A write that changes only the divider leaves lock alone. A new divider exponent takes effect at the next period boundary of the divider. While a stop request is present and the keep-running bit is clear, the source is shut down. After the stop request is removed, a full relock is needed.

Top module: `clkctl_unit`

## Requirements
- R1: After reset the read port returns 0x000000 (ratio field at the default reset value 0x000, divider exponent 0, both control bits clear), the lock flag is low, and the ratio output is 1.
- R2: A write stores bits 17:0 of the write data. The read port returns them in the same positions: ratio bits 11:0, exponent bits 15:12, crystal-off bit 16, keep-running bit 17. Bits 23:18 always read as zero.
- R3: A write whose bits 11:0 differ from the stored ratio clears the lock flag at the clock edge that stores it. The flag rises again at the edge of the RELOCK_TICKS-th reference tick after that write, and cycles without a tick are not counted.
- R4: A write whose bits 11:0 equal the stored ratio does not clear the lock flag and does not restart the relock count.
- R5: A change of the divider exponent, the crystal-off bit or the keep-running bit alone never clears the lock flag.
- R6: With exponent E, the divided enable is high for exactly one of every 2^E reference ticks, for E from 0 to 15. It is high only in a cycle that carries a reference tick.
- R7: A new exponent is taken up only at the tick that ends the current divider period. The period in progress keeps its old length, and the periods after it use the new length.
- R8: When bit 16 is set, the crystal pin is driven high. When bit 16 is clear, the crystal pin follows the oscillator drive input.
- R9: While the stop request is high and bit 17 is clear, the lock flag is low from the next edge onward and the divided enable stays low. When the request is removed, lock returns after a full RELOCK_TICKS count, and the divider starts a fresh period.
- R10: While the stop request is high and bit 17 is set, the lock flag and the divided enable behave as if no stop were requested.
- R11: If a ratio-changing write falls in the same cycle as the tick that would complete a relock count, the restart wins. Lock stays low, and a full new count of RELOCK_TICKS ticks is needed.
- R12: The ratio output equals the stored ratio field plus one, from 1 for 0x000 up to 4096 for 0xFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle tick standing in for the oscillator output |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 24 | Control word to write |
| rd_data | output | 24 | Stored control word, reserved bits zero |
| stop_req | input | 1 | Chip is in the stop state |
| xtal_drv_i | input | 1 | Normal crystal oscillator drive |
| xtal_pin_o | output | 1 | Crystal drive pin |
| mul_ratio_o | output | 13 | Effective multiply ratio (field plus one) |
| lock_o | output | 1 | Lock indication |
| div_en_o | output | 1 | Divided clock enable, one cycle wide |

## Verification
Two pairs of functions can meet in one cycle. In the first, a ratio write coincides with the reference tick that would finish a relock count. In the second, an exponent write lands partway through a divider period while ticks keep arriving. The bench provokes the first by running a relock to one tick short, then issuing a changed ratio together with a tick. It then judges that lock stays low and needs a full fresh count. For the second, the bench writes a larger or smaller exponent two ticks into a period. It measures the tick distance to the next two enables against the old and new period lengths.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
    localparam int CTL_W   = 24;
    localparam int MF_W    = 12;
    localparam int DF_W    = 4;
    localparam int USED_W  = MF_W + DF_W + 2;
    localparam int RSV_W   = CTL_W - USED_W;
    localparam int DIVC_W  = (1 << DF_W) - 1;

    typedef struct packed {
        logic            keep_run;
        logic            xtal_off;
        logic [DF_W-1:0] div_exp;
        logic [MF_W-1:0] mul_fld;
    } ctl_word_t;
endpackage

// File: rtl/clkctl_regs.sv
module clkctl_regs
    import clkctl_pkg::*;
#(
    parameter logic [MF_W-1:0] MF_RESET = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    output ctl_word_t        ctl_o,
    output logic [CTL_W-1:0] rd_data_o,
    output logic             mul_new_o
);
    typedef struct packed {
        ctl_word_t ctl;
    } regs_st_t;

    regs_st_t st_q, st_d;
    logic     mul_new_d;

    always_comb begin
        st_d      = st_q;
        mul_new_d = 1'b0;
        if (wr_en) begin
            st_d.ctl  = ctl_word_t'(wr_data[USED_W-1:0]);
            mul_new_d = (wr_data[MF_W-1:0] != st_q.ctl.mul_fld);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ctl          <= '0;
            st_q.ctl.mul_fld  <= MF_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctl_o     = st_q.ctl;
    assign rd_data_o = {{RSV_W{1'b0}}, st_q.ctl};
    assign mul_new_o = mul_new_d;

    // R4: an unchanged ratio write leaves the stored ratio as it was
    p_same_ratio_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !mul_new_o) |=> $stable(st_q.ctl.mul_fld));
endmodule

// File: rtl/clkctl_lock.sv
module clkctl_lock #(
    parameter int RELOCK_TICKS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    input  logic ref_tick,
    output logic locked_o
);
    localparam int CNT_W = $clog2(RELOCK_TICKS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RELOCK_TICKS - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             locked;
    } lock_st_t;

    lock_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (!run || restart) begin
            st_d.cnt    = '0;
            st_d.locked = 1'b0;
        end else if (ref_tick && !st_q.locked) begin
            if (st_q.cnt == LAST) begin
                st_d.cnt    = '0;
                st_d.locked = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign locked_o = st_q.locked;

    // R3: a restart always drops lock at the next edge
    p_restart_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !locked_o);
    // R3: lock only rises on a counted tick with the source running
    p_rise_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked_o) |-> $past(ref_tick && run && !restart));
    // R11: counter never passes the final value
    p_cnt_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST);
endmodule

// File: rtl/clkctl_div.sv
module clkctl_div
    import clkctl_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            ref_tick,
    input  logic [DF_W-1:0] exp_req,
    output logic            div_en_o
);
    typedef struct packed {
        logic [DIVC_W-1:0] cnt;
        logic [DF_W-1:0]   act_exp;
    } div_st_t;

    div_st_t           st_q, st_d;
    logic [DIVC_W:0]   pow_q;
    logic [DIVC_W-1:0] lim_q;
    logic              edge_hit;

    always_comb begin
        pow_q    = (DIVC_W + 1)'(1) << st_q.act_exp;
        lim_q    = DIVC_W'(pow_q - 1'b1);
        edge_hit = run && ref_tick && (st_q.cnt == lim_q);
        st_d     = st_q;
        if (!run) begin
            st_d.cnt     = '0;
            st_d.act_exp = exp_req;
        end else if (ref_tick) begin
            if (edge_hit) begin
                st_d.cnt     = '0;
                st_d.act_exp = exp_req;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign div_en_o = edge_hit;

    // R7: the period counter never runs past the active limit
    p_cnt_in_period_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= lim_q);
    // R7: active exponent only moves when the counter sits at period start
    p_exp_at_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.act_exp) |-> (st_q.cnt == '0));
    // R6: with a ratio above one, two enables never come back to back
    p_en_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (div_en_o && st_q.act_exp != '0 && exp_req != '0) |=> !div_en_o);
endmodule

// File: rtl/clkctl_unit.sv
module clkctl_unit
    import clkctl_pkg::*;
#(
    parameter int              RELOCK_TICKS = 64,
    parameter logic [MF_W-1:0] MF_RESET     = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    output logic [CTL_W-1:0] rd_data,
    input  logic             stop_req,
    input  logic             xtal_drv_i,
    output logic             xtal_pin_o,
    output logic [MF_W:0]    mul_ratio_o,
    output logic             lock_o,
    output logic             div_en_o
);
    ctl_word_t ctl;
    logic      mul_new;
    logic      src_run;

    clkctl_regs #(.MF_RESET(MF_RESET)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .ctl_o     (ctl),
        .rd_data_o (rd_data),
        .mul_new_o (mul_new)
    );

    assign src_run = !(stop_req && !ctl.keep_run);

    clkctl_lock #(.RELOCK_TICKS(RELOCK_TICKS)) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (src_run),
        .restart  (mul_new),
        .ref_tick (ref_tick),
        .locked_o (lock_o)
    );

    clkctl_div u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (src_run),
        .ref_tick (ref_tick),
        .exp_req  (ctl.div_exp),
        .div_en_o (div_en_o)
    );

    assign xtal_pin_o  = ctl.xtal_off | xtal_drv_i;
    assign mul_ratio_o = {1'b0, ctl.mul_fld} + (MF_W + 1)'(1);

    // R5: a write that keeps the ratio never costs lock
    p_keep_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[MF_W-1:0] == ctl.mul_fld && src_run && lock_o) |=> lock_o);
    // R9: stopped source means no lock after the next edge
    p_stop_unlock_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req && !ctl.keep_run) |=> !lock_o);
    // R9: no divided enable while the source is stopped
    p_stop_no_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req && !ctl.keep_run) |-> !div_en_o);
    // R2: reserved bits of the read port stay zero
    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[CTL_W-1:USED_W] == '0);
endmodule

// File: tb/clkctl_unit_test.sv
module clkctl_unit_test;
    localparam int PERIOD = 10;
    localparam int RLK    = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [23:0] wr_data = '0;
    logic [23:0] rd_data;
    logic        stop_req = 1'b0;
    logic        xtal_drv_i = 1'b0;
    logic        xtal_pin_o;
    logic [12:0] mul_ratio_o;
    logic        lock_o;
    logic        div_en_o;

    int n_chk = 0;
    int n_bad = 0;
    logic en_seen;
    logic [11:0] cur_mf = '0;

    clkctl_unit #(.RELOCK_TICKS(RLK)) uut (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .stop_req(stop_req),
        .xtal_drv_i(xtal_drv_i), .xtal_pin_o(xtal_pin_o),
        .mul_ratio_o(mul_ratio_o), .lock_o(lock_o), .div_en_o(div_en_o)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic done();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    function automatic logic [23:0] word(input logic keep, input logic xoff,
                                         input logic [3:0] e, input logic [11:0] m);
        return {6'b0, keep, xoff, e, m};
    endfunction

    // one cycle: enable observed mid-cycle, registers read after the edge
    task automatic step(input logic t);
        ref_tick = t;
        @(negedge clk);
        en_seen = div_en_o;
        @(posedge clk);
        #1;
        ref_tick = 1'b0;
        wr_en    = 1'b0;
    endtask

    task automatic wr(input logic [23:0] d, input logic t);
        wr_en = 1'b1;
        wr_data = d;
        step(t);
        cur_mf = d[11:0];
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(1'b1);
    endtask

    task automatic to_pulse(output int n);
        n = 0;
        for (int i = 0; i < 40000; i++) begin
            step(1'b1);
            n++;
            if (en_seen) break;
        end
    endtask

    initial begin
        #(PERIOD * 190000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        done();
    end

    initial begin
        int g;
        int cnt;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        chk("R1 rd_data", int'(rd_data), 0);
        chk("R1 lock", int'(lock_o), 0);
        chk("R1 ratio", int'(mul_ratio_o), 1);
        // R3 power-up relock with idle gaps
        for (int i = 0; i < RLK - 1; i++) begin step(1'b1); step(1'b0); end
        chk("R3 lock before count", int'(lock_o), 0);
        step(1'b1);
        chk("R3 lock after count", int'(lock_o), 1);

        // R2 readback, reserved bits zero
        wr(24'hFFFFFF, 1'b0);
        chk("R2 rsvd zero", int'(rd_data), 24'h03FFFF);
        wr(24'hA5C3E7, 1'b0);
        chk("R2 pattern", int'(rd_data), 24'h01C3E7);
        // R12 ratio sweep at the ends and a few points
        for (int v = 0; v < 4096; v += 273) begin
            wr(word(0, 0, 0, 12'(v)), 1'b0);
            chk("R12 ratio", int'(mul_ratio_o), v + 1);
        end
        wr(word(0, 0, 0, 12'hFFF), 1'b0);
        chk("R12 ratio max", int'(mul_ratio_o), 4096);

        // R3 changed ratio drops lock, RLK ticks to relock
        wr(word(0, 0, 0, 12'h055), 1'b0);
        chk("R3 drop", int'(lock_o), 0);
        ticks(RLK - 1);
        chk("R3 still low", int'(lock_o), 0);
        ticks(1);
        chk("R3 relocked", int'(lock_o), 1);
        // R4 same ratio, R5 other fields changed
        wr(word(1, 1, 4'd5, 12'h055), 1'b1);
        chk("R4 R5 lock kept", int'(lock_o), 1);
        wr(word(0, 0, 4'd0, 12'h055), 1'b0);
        chk("R5 lock kept", int'(lock_o), 1);
        // R4 same-ratio write mid relock does not restart count
        wr(word(0, 0, 0, 12'h056), 1'b0);
        ticks(RLK - 2);
        wr(word(0, 0, 0, 12'h056), 1'b0);
        ticks(1);
        chk("R4 no restart", int'(lock_o), 0);
        ticks(1);
        chk("R4 count continued", int'(lock_o), 1);
        // R11 ratio change on the completing tick
        wr(word(0, 0, 0, 12'h0AA), 1'b0);
        ticks(RLK - 1);
        wr(word(0, 0, 0, 12'h0AB), 1'b1);
        chk("R11 restart wins", int'(lock_o), 0);
        ticks(RLK - 1);
        chk("R11 full count low", int'(lock_o), 0);
        ticks(1);
        chk("R11 full count done", int'(lock_o), 1);

        // R6 divider sweep
        for (int e = 0; e <= 15; e++) begin
            if (e > 12 && e < 15) continue;
            wr(word(0, 0, 4'(e), cur_mf), 1'b0);
            to_pulse(g);
            for (int p = 0; p < ((e == 15) ? 1 : 2); p++) begin
                if (e <= 4) begin
                    g = 0;
                    for (int i = 0; i < 40; i++) begin
                        step(1'b0);
                        if (en_seen) chk("R6 en without tick", 1, 0);
                        step(1'b1);
                        g++;
                        if (en_seen) break;
                    end
                end else begin
                    to_pulse(g);
                end
                chk($sformatf("R6 period e=%0d", e), g, 1 << e);
            end
        end
        chk("R5 lock through divider", int'(lock_o), 1);

        // R7 growing and shrinking mid period
        wr(word(0, 0, 4'd3, cur_mf), 1'b0);
        to_pulse(g);
        to_pulse(g);
        ticks(2);
        wr(word(0, 0, 4'd0, cur_mf), 1'b0);
        to_pulse(g);
        chk("R7 old period finished", g, 6);
        to_pulse(g);
        chk("R7 new period", g, 1);
        wr(word(0, 0, 4'd2, cur_mf), 1'b0);
        to_pulse(g);
        chk("R7 shrink edge", g, 1);
        to_pulse(g);
        chk("R7 grown period", g, 4);

        // R8 crystal pin
        for (int x = 0; x < 2; x++) begin
            for (int d = 0; d < 2; d++) begin
                wr(word(0, 1'(x), 4'd2, cur_mf), 1'b0);
                xtal_drv_i = 1'(d);
                #1;
                chk("R8 pin", int'(xtal_pin_o), (x == 1) ? 1 : d);
            end
        end
        xtal_drv_i = 1'b0;

        // R9 stop with source shut down
        wr(word(0, 0, 4'd1, cur_mf), 1'b0);
        to_pulse(g);
        stop_req = 1'b1;
        cnt = 0;
        for (int i = 0; i < 6; i++) begin step(1'b1); if (en_seen) cnt++; end
        chk("R9 no enable", cnt, 0);
        chk("R9 lock low", int'(lock_o), 0);
        stop_req = 1'b0;
        to_pulse(g);
        chk("R9 fresh period", g, 2);
        ticks(RLK - 3);
        chk("R9 relock pending", int'(lock_o), 0);
        ticks(1);
        chk("R9 relocked", int'(lock_o), 1);

        // R10 stop with source kept running
        wr(word(1, 0, 4'd1, cur_mf), 1'b0);
        to_pulse(g);
        stop_req = 1'b1;
        cnt = 0;
        for (int i = 0; i < 8; i++) begin step(1'b1); if (en_seen) cnt++; end
        chk("R10 enables", cnt, 4);
        chk("R10 lock kept", int'(lock_o), 1);
        stop_req = 1'b0;
        step(1'b0);
        done();
    end
endmodule